// File: doc/BRIEF.md
# Self-Clearing Soft Reset Sequencer

This block sits beside a two-clock USB-style core and turns three software reset requests into ordered reset activity. The requests are self-clearing bits in one control word. One bit clears the frame counter. One bit returns the bus-side state machines to idle. One bit resets the whole core. The control word also reports whether the bus master is idle.

A bus-side reset waits until the bus state machines report that their transaction is done. It then pulses their reset and clears the bus-owned configuration bits. FIFO contents and interrupt status are left alone. A full reset starts a toggle handshake into the PHY clock domain at once, so USB-side activity stops immediately. It waits until the current bus master data phase has ended. It then pulses the FIFO flush, the master abort and the state-machine reset together, and clears every configuration bit outside a preserved mask, along with the interrupt status and the frame counter. The request bit drops only when the PHY-domain acknowledge has come back through a synchronizer.

The sequencer is a six-state machine:
- `ST_IDLE` goes to `ST_CORE_DRAIN` on a full request, or to `ST_BUS_DRAIN` on a bus-only request.
- `ST_BUS_DRAIN` goes to `ST_CORE_DRAIN` if a full request arrives while it waits, or to `ST_BUS_APPLY` once the bus state machines are idle.
- `ST_BUS_APPLY` returns to `ST_IDLE` after one cycle.
- `ST_CORE_DRAIN` goes to `ST_CORE_APPLY` once the bus master is idle.
- `ST_CORE_APPLY` goes to `ST_CORE_WAIT` after one cycle.
- `ST_CORE_WAIT` returns to `ST_IDLE` when the PHY acknowledge matches the request toggle.

Top module: `softrst_ctrl`

## Requirements
- R1: After reset, the control word (address 0) reads 0x8000_0000 while `bm_busy` is low. The configuration word (address 1) and the interrupt status (address 2) read 0, `frame_num` is 0 and no strobe is active.
- R2: `frame_num` counts up by one per `sof_tick`. In host mode (`host_mode`=1), writing 1 to control bit 2 sets `frame_num` to 0 one cycle after the write is captured, and the bit reads 0 again in that same cycle. In device mode the write is ignored and the count continues.
- R3: Writing 1 to control bit 1 starts a bus reset. No strobe is issued while `sm_busy` is high. After `sm_busy` falls, one single-cycle `bus_sm_rst` pulse is issued without `fifo_flush`. The pulse clears the configuration bits in BUS_CLR_MASK (default bits 16..8) and keeps the other configuration bits and the interrupt status. Bit 1 then reads 0.
- R4: Writing 1 to control bit 0 starts a full reset. `fifo_flush`, `mst_abort` and `bus_sm_rst` pulse together for one cycle, and only after `bm_busy` has been low. The pulse clears every configuration bit outside KEEP_MASK (default bits 7..0), the interrupt status and `frame_num`.
- R5: A full reset drives `phy_rst` in the PHY domain for exactly PHY_RST_CYC PHY clocks, starting while the bus master may still be busy. Control bit 0 reads 1 until both the flush pulse has occurred and the PHY acknowledge has returned.
- R6: A write of 1 to a reset bit that is already 1 does not restart or repeat the sequence. A write of 0 to a reset bit leaves it unchanged.
- R7: A full request takes priority over a bus request. If both are written together, or if a full request arrives while a bus reset waits, only the full sequence runs (one flush pulse), and bits 0 and 1 clear in the same cycle.
- R8: Control bit 3 and bits 30..4 read 0 whatever is written. Bit 31 reads as the inverse of `bm_busy`.
- R9: Each `irq_set` bit sets the matching interrupt status bit at address 2. Writing 1 to a status bit at address 2 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-domain clock |
| rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| phy_clk | input | 1 | PHY-domain clock |
| phy_rst_n | input | 1 | PHY-domain asynchronous reset, active low |
| host_mode | input | 1 | 1 when the core runs as host |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 configuration, 2 interrupt status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| sm_busy | input | 1 | Bus state machines are inside a transaction |
| bm_busy | input | 1 | Bus master data phase is in progress |
| sof_tick | input | 1 | A start-of-frame was sent; advance the frame number |
| irq_set | input | IRQ_W | Interrupt event pulses |
| frame_num | output | FRAME_W | Frame number for the next start-of-frame |
| cfg_out | output | DATA_W | Configuration bits driven to the core |
| bus_sm_rst | output | 1 | One-cycle reset to the bus-domain state machines |
| fifo_flush | output | 1 | One-cycle flush to all FIFOs |
| mst_abort | output | 1 | One-cycle abort to the bus master |
| phy_rst | output | 1 | PHY-domain reset and USB abort, in `phy_clk` domain |

## Verification
A bus-side reset and a full reset can fall into the same sequence. They can be requested in the same write, or a full request can land while a bus reset is still waiting on `sm_busy`. Both cases are provoked by writing 3 to the control word, and by writing bit 1 with `sm_busy` held high and then bit 0 a few cycles later. The scoreboard expects exactly one strobe, with flush and abort set, and no separate bus-only pulse. It then checks that bits 0 and 1 read 0 together once the PHY pulse has completed.

// File: rtl/softrst_pkg.sv
package softrst_pkg;

    // Control-word bit positions (software-visible encoding)
    localparam int CTL_CORE = 0;
    localparam int CTL_BUS  = 1;
    localparam int CTL_FRM  = 2;

    // Register select codes
    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_CFG = 2'd1;
    localparam logic [1:0] ADDR_IRQ = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUS_DRAIN,
        ST_BUS_APPLY,
        ST_CORE_DRAIN,
        ST_CORE_APPLY,
        ST_CORE_WAIT
    } seq_state_t;

endpackage

// File: rtl/softrst_sync.sv
module softrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff <= '0;
        end else begin
            ff <= STAGES'({ff, d});
        end
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/softrst_phy_agent.sv
module softrst_phy_agent #(
    parameter int PHY_RST_CYC = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic phy_clk,
    input  logic phy_rst_n,
    input  logic req_tgl,
    output logic ack_tgl,
    output logic phy_rst
);
    localparam int CW = $clog2(PHY_RST_CYC + 1);

    logic          req_s;
    logic          req_seen;
    logic [CW-1:0] cnt;

    softrst_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (phy_clk),
        .rst_n (phy_rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    always_ff @(posedge phy_clk or negedge phy_rst_n) begin
        if (!phy_rst_n) begin
            req_seen <= 1'b0;
            cnt      <= '0;
            ack_tgl  <= 1'b0;
        end else if (req_s != req_seen) begin
            req_seen <= req_s;
            cnt      <= CW'(PHY_RST_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                ack_tgl <= ~ack_tgl;
            end
        end
    end

    assign phy_rst = (cnt != '0);
endmodule

// File: rtl/softrst_fsm.sv
module softrst_fsm
    import softrst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_req,
    input  logic bus_req,
    input  logic sm_busy,
    input  logic bm_busy,
    input  logic ack_tgl,
    output logic req_tgl,
    output logic bus_sm_rst,
    output logic fifo_flush,
    output logic mst_abort,
    output logic clr_bus,
    output logic clr_all,
    output logic done_bus,
    output logic done_core
);
    seq_state_t state;
    seq_state_t nxt;
    logic       flip;
    logic       phy_done;

    assign phy_done = (ack_tgl == req_tgl);

    // State register and handshake toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            req_tgl <= 1'b0;
        end else begin
            state <= nxt;
            if (flip) begin
                req_tgl <= ~req_tgl;
            end
        end
    end

    // Transitions and strobes
    always_comb begin
        nxt        = state;
        flip       = 1'b0;
        bus_sm_rst = 1'b0;
        fifo_flush = 1'b0;
        mst_abort  = 1'b0;
        clr_bus    = 1'b0;
        clr_all    = 1'b0;
        done_bus   = 1'b0;
        done_core  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (core_req) begin
                    nxt  = ST_CORE_DRAIN;
                    flip = 1'b1;
                end else if (bus_req) begin
                    nxt = ST_BUS_DRAIN;
                end
            end
            ST_BUS_DRAIN: begin
                if (core_req) begin
                    nxt  = ST_CORE_DRAIN;
                    flip = 1'b1;
                end else if (!sm_busy) begin
                    nxt = ST_BUS_APPLY;
                end
            end
            ST_BUS_APPLY: begin
                bus_sm_rst = 1'b1;
                clr_bus    = 1'b1;
                done_bus   = 1'b1;
                nxt        = ST_IDLE;
            end
            ST_CORE_DRAIN: begin
                if (!bm_busy) begin
                    nxt = ST_CORE_APPLY;
                end
            end
            ST_CORE_APPLY: begin
                bus_sm_rst = 1'b1;
                fifo_flush = 1'b1;
                mst_abort  = 1'b1;
                clr_all    = 1'b1;
                nxt        = ST_CORE_WAIT;
            end
            ST_CORE_WAIT: begin
                if (phy_done) begin
                    done_core = 1'b1;
                    nxt       = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/softrst_ctrl.sv
module softrst_ctrl
    import softrst_pkg::*;
#(
    parameter int              DATA_W       = 32,
    parameter int              IRQ_W        = 8,
    parameter int              FRAME_W      = 11,
    parameter int              PHY_RST_CYC  = 4,
    parameter int              SYNC_STAGES  = 2,
    parameter logic [DATA_W-1:0] KEEP_MASK    = 32'h0000_00FF,
    parameter logic [DATA_W-1:0] BUS_CLR_MASK = 32'h0001_FF00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phy_clk,
    input  logic               phy_rst_n,
    input  logic               host_mode,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               sm_busy,
    input  logic               bm_busy,
    input  logic               sof_tick,
    input  logic [IRQ_W-1:0]   irq_set,
    output logic [FRAME_W-1:0] frame_num,
    output logic [DATA_W-1:0]  cfg_out,
    output logic               bus_sm_rst,
    output logic               fifo_flush,
    output logic               mst_abort,
    output logic               phy_rst
);
    localparam int IDLE_BIT = DATA_W - 1;

    logic             core_req_q;
    logic             bus_req_q;
    logic             frm_req_q;
    logic [IRQ_W-1:0] irq_q;
    logic             wr_ctl, wr_cfg, wr_irq;
    logic             clr_bus, clr_all, done_bus, done_core;
    logic             req_tgl, ack_tgl_phy, ack_tgl_bus;
    logic [DATA_W-1:0] ctl_word;

    assign wr_ctl = reg_wr_en && (reg_addr == ADDR_CTL);
    assign wr_cfg = reg_wr_en && (reg_addr == ADDR_CFG);
    assign wr_irq = reg_wr_en && (reg_addr == ADDR_IRQ);

    // Self-clearing request bits; a set is taken only while the bit is 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_req_q <= 1'b0;
            bus_req_q  <= 1'b0;
            frm_req_q  <= 1'b0;
        end else begin
            if (core_req_q) core_req_q <= !done_core;
            else            core_req_q <= wr_ctl && reg_wdata[CTL_CORE];

            if (bus_req_q) bus_req_q <= !(done_bus || done_core);
            else           bus_req_q <= wr_ctl && reg_wdata[CTL_BUS];

            if (frm_req_q) frm_req_q <= 1'b0;
            else           frm_req_q <= wr_ctl && reg_wdata[CTL_FRM] && host_mode;
        end
    end

    // Configuration word with preserved and bus-owned masks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_out <= '0;
        end else if (clr_all) begin
            cfg_out <= cfg_out & KEEP_MASK;
        end else if (clr_bus) begin
            cfg_out <= cfg_out & ~BUS_CLR_MASK;
        end else if (wr_cfg) begin
            cfg_out <= reg_wdata;
        end
    end

    // Interrupt status: set by events, write-one-to-clear, wiped by full reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else if (clr_all) begin
            irq_q <= '0;
        end else begin
            irq_q <= (irq_q & ~(wr_irq ? reg_wdata[IRQ_W-1:0] : '0)) | irq_set;
        end
    end

    // Frame number counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_num <= '0;
        end else if (clr_all || frm_req_q) begin
            frame_num <= '0;
        end else if (sof_tick) begin
            frame_num <= frame_num + 1'b1;
        end
    end

    always_comb begin
        ctl_word           = '0;
        ctl_word[CTL_CORE] = core_req_q;
        ctl_word[CTL_BUS]  = bus_req_q;
        ctl_word[CTL_FRM]  = frm_req_q;
        ctl_word[IDLE_BIT] = !bm_busy;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTL: reg_rdata = ctl_word;
            ADDR_CFG: reg_rdata = cfg_out;
            ADDR_IRQ: reg_rdata = {{(DATA_W-IRQ_W){1'b0}}, irq_q};
            default:  reg_rdata = '0;
        endcase
    end

    softrst_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_req   (core_req_q),
        .bus_req    (bus_req_q),
        .sm_busy    (sm_busy),
        .bm_busy    (bm_busy),
        .ack_tgl    (ack_tgl_bus),
        .req_tgl    (req_tgl),
        .bus_sm_rst (bus_sm_rst),
        .fifo_flush (fifo_flush),
        .mst_abort  (mst_abort),
        .clr_bus    (clr_bus),
        .clr_all    (clr_all),
        .done_bus   (done_bus),
        .done_core  (done_core)
    );

    softrst_phy_agent #(
        .PHY_RST_CYC (PHY_RST_CYC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_phy (
        .phy_clk   (phy_clk),
        .phy_rst_n (phy_rst_n),
        .req_tgl   (req_tgl),
        .ack_tgl   (ack_tgl_phy),
        .phy_rst   (phy_rst)
    );

    softrst_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl_phy),
        .q     (ack_tgl_bus)
    );
endmodule

// File: rtl/softrst_chk.sv
module softrst_chk #(
    parameter int                DATA_W    = 32,
    parameter int                FRAME_W   = 11,
    parameter logic [DATA_W-1:0] KEEP_MASK = 32'h0000_00FF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sm_busy,
    input logic               bm_busy,
    input logic               bus_sm_rst,
    input logic               fifo_flush,
    input logic [DATA_W-1:0]  cfg_out,
    input logic [FRAME_W-1:0] frame_num,
    input logic               core_req,
    input logic               frm_req
);
    logic flush_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flush_seen <= 1'b0;
        else if (!core_req)  flush_seen <= 1'b0;
        else if (fifo_flush) flush_seen <= 1'b1;
    end

    p_frame_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_req |=> (frame_num == '0));

    p_frame_selfclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_req |=> !frm_req);

    p_bus_strobe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sm_rst && !fifo_flush) |-> $past(!sm_busy));

    p_flush_after_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> $past(!bm_busy));

    p_keep_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> ((cfg_out & KEEP_MASK) == ($past(cfg_out) & KEEP_MASK)));

    p_cfg_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> ((cfg_out & ~KEEP_MASK) == '0));

    p_core_clear_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_req) |-> flush_seen);
endmodule

bind softrst_ctrl softrst_chk #(
    .DATA_W    (DATA_W),
    .FRAME_W   (FRAME_W),
    .KEEP_MASK (KEEP_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sm_busy    (sm_busy),
    .bm_busy    (bm_busy),
    .bus_sm_rst (bus_sm_rst),
    .fifo_flush (fifo_flush),
    .cfg_out    (cfg_out),
    .frame_num  (frame_num),
    .core_req   (core_req_q),
    .frm_req    (frm_req_q)
);

// File: tb/test_softrst_ctrl.sv
`timescale 1ns/1ps
module test_softrst_ctrl;
    localparam int PHY_CYC = 4;

    logic        clk = 1'b0;
    logic        phy_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phy_rst_n = 1'b0;
    logic        host_mode = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sm_busy = 1'b0;
    logic        bm_busy = 1'b0;
    logic        sof_tick = 1'b0;
    logic [7:0]  irq_set = '0;
    logic [10:0] frame_num;
    logic [31:0] cfg_out;
    logic        bus_sm_rst, fifo_flush, mst_abort, phy_rst;

    int vecs = 0;
    int errs = 0;
    int phy_hi = 0;
    int exp_q[$];

    always #2 clk = ~clk;
    always #5 phy_clk = ~phy_clk;

    softrst_ctrl #(.PHY_RST_CYC(PHY_CYC)) i_softrst_ctrl (
        .clk(clk), .rst_n(rst_n), .phy_clk(phy_clk), .phy_rst_n(phy_rst_n),
        .host_mode(host_mode), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sm_busy(sm_busy),
        .bm_busy(bm_busy), .sof_tick(sof_tick), .irq_set(irq_set),
        .frame_num(frame_num), .cfg_out(cfg_out), .bus_sm_rst(bus_sm_rst),
        .fifo_flush(fifo_flush), .mst_abort(mst_abort), .phy_rst(phy_rst)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [31:0] e, input string req);
        logic [31:0] d;
        rd(a, d);
        check(d == e, req, d, e);
    endtask

    task automatic wait_clear(input int b, input string req);
        logic [31:0] d;
        int n;
        n = 0;
        rd(2'd0, d);
        while (d[b] && n < 400) begin
            rd(2'd0, d);
            n++;
        end
        check(!d[b], req, d, d & ~(32'd1 << b));
    endtask

    task automatic sof_pulse();
        @(negedge clk); sof_tick = 1'b1;
        @(negedge clk); sof_tick = 1'b0;
    endtask

    task automatic irq_pulse(input logic [7:0] v);
        @(negedge clk); irq_set = v;
        @(negedge clk); irq_set = '0;
    endtask

    // Scoreboard monitor: 1 = bus-only strobe, 2 = full strobe
    always @(negedge clk) begin
        if (rst_n && (bus_sm_rst || fifo_flush)) begin
            int code;
            int e;
            code = fifo_flush ? 2 : 1;
            if (exp_q.size() == 0) begin
                vecs++; errs++;
                $display("FAIL R6: unexpected strobe actual %0d expected none", code);
            end else begin
                e = exp_q.pop_front();
                check(code == e && mst_abort == fifo_flush,
                      (e == 2) ? "R4 strobe" : "R3 strobe", 32'(code), 32'(e));
            end
        end
    end

    always @(negedge phy_clk) if (phy_rst) phy_hi++;

    initial begin
        #400000;
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; phy_rst_n = 1'b1;

        // R1 / R8: reset state
        expect_rd(2'd0, 32'h8000_0000, "R1 ctl");
        expect_rd(2'd1, 32'h0, "R1 cfg");
        expect_rd(2'd2, 32'h0, "R1 irq");
        check(frame_num == 0, "R1 frame", 32'(frame_num), 0);

        // R2: counting and host-mode frame reset
        repeat (3) sof_pulse();
        check(frame_num == 3, "R2 count", 32'(frame_num), 3);
        wr(2'd0, 32'h4);
        @(negedge clk);
        check(frame_num == 0, "R2 cleared", 32'(frame_num), 0);
        expect_rd(2'd0, 32'h8000_0000, "R2 selfclear");
        host_mode = 1'b0;
        repeat (2) sof_pulse();
        wr(2'd0, 32'h4);
        @(negedge clk);
        check(frame_num == 2, "R2 device ignore", 32'(frame_num), 2);
        host_mode = 1'b1;

        // R9: interrupt status
        wr(2'd1, 32'h0003_FFFF);
        irq_pulse(8'h05);
        expect_rd(2'd2, 32'h05, "R9 set");

        // R3 / R6: bus reset held off by busy state machines
        sm_busy = 1'b1;
        exp_q.push_back(1);
        wr(2'd0, 32'h2);
        repeat (10) @(negedge clk);
        expect_rd(2'd0, 32'h8000_0002, "R3 waits");
        wr(2'd0, 32'h2);
        wr(2'd0, 32'h0);
        expect_rd(2'd0, 32'h8000_0002, "R6 write0 no effect");
        sm_busy = 1'b0;
        wait_clear(1, "R3 selfclear");
        expect_rd(2'd1, 32'h0002_00FF, "R3 cfg mask");
        expect_rd(2'd2, 32'h05, "R3 irq kept");
        irq_pulse(8'h30);
        wr(2'd2, 32'h01);
        expect_rd(2'd2, 32'h34, "R9 w1c");

        // R4 / R5: full reset waits for master data phase
        repeat (3) sof_pulse();
        wr(2'd1, 32'hFFFF_FFFF);
        bm_busy = 1'b1;
        phy_hi = 0;
        exp_q.push_back(2);
        wr(2'd0, 32'h1);
        repeat (40) @(negedge clk);
        expect_rd(2'd0, 32'h0000_0001, "R5 held while master busy");
        check(phy_hi == PHY_CYC, "R5 phy pulse early", 32'(phy_hi), 32'(PHY_CYC));
        bm_busy = 1'b0;
        wait_clear(0, "R5 selfclear");
        expect_rd(2'd1, 32'h0000_00FF, "R4 keep mask");
        expect_rd(2'd2, 32'h0, "R4 irq cleared");
        check(frame_num == 0, "R4 frame cleared", 32'(frame_num), 0);
        check(phy_hi == PHY_CYC, "R5 phy pulse width", 32'(phy_hi), 32'(PHY_CYC));

        // R7: both requested together
        phy_hi = 0;
        exp_q.push_back(2);
        wr(2'd0, 32'h3);
        wait_clear(0, "R7 together");
        expect_rd(2'd0, 32'h8000_0000, "R7 both clear");
        check(phy_hi == PHY_CYC, "R7 phy pulse", 32'(phy_hi), 32'(PHY_CYC));

        // R7: full request upgrades a waiting bus reset
        sm_busy = 1'b1;
        exp_q.push_back(2);
        wr(2'd0, 32'h2);
        repeat (3) @(negedge clk);
        wr(2'd0, 32'h1);
        wait_clear(0, "R7 upgrade");
        expect_rd(2'd0, 32'h8000_0000, "R7 upgrade both clear");
        sm_busy = 1'b0;
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R7 strobe count", 32'(exp_q.size()), 0);

        // R8: reserved bits and idle flag
        wr(2'd0, 32'hFFFF_FFF8);
        expect_rd(2'd0, 32'h8000_0000, "R8 reserved");
        bm_busy = 1'b1;
        expect_rd(2'd0, 32'h0000_0000, "R8 idle flag");
        bm_busy = 1'b0;

        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule